// File: doc/BRIEF.md
# Serially Reconfigurable Five-Input Look-Up Table Chain

This block is a chain of five-input look-up tables whose truth tables can be rewritten while the surrounding logic keeps running. Each cell keeps a 32-bit table in a shift register. A five-bit select reads one bit of that table as the main output. A second output reads only the lower half of the table, addressed by the four low select bits. With the top select bit tied high, the two outputs act as two independent four-input functions of the same four inputs. With that bit in normal use, the pair gives a five-input function together with a four-input function that is part of it.

The table is replaced one bit per enabled clock. New bits enter bit 0 of the first cell and move toward bit 31. Bit 31 of each cell feeds bit 0 of the next cell, so a single serial stream of 32 bits per cell reprograms the whole chain. The last cell's bit 31 is also brought out as a cascade output. A parameter sets the contents after reset, which are all zeros by default. Another parameter makes the falling clock edge the active edge.

A small loader tracks one reprogramming pass. After a start pulse it counts enabled clocks. When 32 times the number of cells have been counted, it raises a one-cycle done flag.

Top module: `lut5_shift_chain`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released, each cell k holds table bits CELL_INIT[32k+31:32k], and load_busy and load_done are 0.
- R2: out6[k] equals bit {i4,i3,i2,i1,i0} of cell k's current table, where lut_in[5k+j] is input ij. The output is combinational in lut_in.
- R3: out5[k] equals bit {i3,i2,i1,i0} of cell k's table, so it reads bits 15..0 only. When i4 is 0, out5[k] equals out6[k]. When i4 is 1, out6[k] reads bits 31..16, independently of out5[k].
- R4: On every active clock edge with shift_en high, each cell's table moves one place toward bit 31. Bit 0 of cell 0 takes ser_in.
- R5: On an active edge with shift_en low, no table changes, whatever ser_in does.
- R6: Bit 0 of cell k>0 takes the old bit 31 of cell k-1, and ser_out is bit 31 of the last cell. After 32·N_CELLS uninterrupted shifts, the first bit presented sits in bit 31 of the last cell and the last bit presented sits in bit 0 of cell 0.
- R7: A load_start pulse sets load_busy on the next edge. After the 32·N_CELLS-th enabled edge that follows, load_busy is 0 and load_done is 1 for exactly one cycle.
- R8: Enabled clocks taken while load_busy is 0 are not counted, and load_done stays 0 when no load is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reconfiguration clock (edge set by CLK_FALL) |
| rst_n | input | 1 | Asynchronous active-low reset to CELL_INIT |
| shift_en | input | 1 | Active-high shift enable |
| ser_in | input | 1 | Serial table data into cell 0 |
| ser_out | output | 1 | Bit 31 of the last cell |
| lut_in | input | 5·N_CELLS | Logic inputs, five per cell |
| out5 | output | N_CELLS | Four-input output per cell |
| out6 | output | N_CELLS | Five-input output per cell |
| load_start | input | 1 | Starts a counted reprogramming pass |
| load_busy | output | 1 | Pass in progress |
| load_done | output | 1 | One-cycle pulse when the pass is complete |

## Verification
Several unrelated 64-bit table pairs are streamed through the chain. For each pair, all 32 select codes are swept on both cells. Reading every code of both outputs on both cells would catch a reversed stream order, a swapped cell order or a wrong select bit. A sweep after clocks with the enable low and a toggling serial input tells holding apart from shifting. A short unloaded shift of a known bit pattern shows the one-place move, the carry across cells and that the loader ignores clocks it was not started for.

// File: rtl/lut5_pkg.sv
package lut5_pkg;
    localparam int unsigned LUT_INPUTS = 5;
    localparam int unsigned TBL_BITS   = 1 << LUT_INPUTS;
    localparam int unsigned HALF_SEL   = LUT_INPUTS - 1;

    typedef logic [TBL_BITS-1:0] tbl_t;
    typedef logic [LUT_INPUTS-1:0] sel_t;
endpackage

// File: rtl/lut5_table_reg.sv
module lut5_table_reg
    import lut5_pkg::*;
#(
    parameter tbl_t INIT     = '0,
    parameter bit   CLK_FALL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic ser_in,
    output logic ser_out,
    output tbl_t tbl
);
    typedef struct packed {
        tbl_t bits;
    } tr_state_t;

    tr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (shift_en) begin
            s_d.bits = {s_q.bits[TBL_BITS-2:0], ser_in};
        end
    end

    generate
        if (CLK_FALL) begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) s_q.bits <= INIT;
                else        s_q      <= s_d;
            end
        end else begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q.bits <= INIT;
                else        s_q      <= s_d;
            end
        end
    endgenerate

    assign ser_out = s_q.bits[TBL_BITS-1];
    assign tbl     = s_q.bits;
endmodule

// File: rtl/lut5_read.sv
module lut5_read
    import lut5_pkg::*;
(
    input  tbl_t tbl,
    input  sel_t sel,
    output logic out5,
    output logic out6
);
    logic [HALF_SEL-1:0] low_sel;

    always_comb begin
        low_sel = sel[HALF_SEL-1:0];
        out6    = tbl[sel];
        out5    = tbl[{1'b0, low_sel}];
    end
endmodule

// File: rtl/lut5_cell.sv
module lut5_cell
    import lut5_pkg::*;
#(
    parameter tbl_t INIT     = '0,
    parameter bit   CLK_FALL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic casc_in,
    output logic casc_out,
    input  sel_t sel,
    output logic out5,
    output logic out6,
    output tbl_t tbl
);
    tbl_t tbl_w;

    lut5_table_reg #(.INIT(INIT), .CLK_FALL(CLK_FALL)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .ser_in   (casc_in),
        .ser_out  (casc_out),
        .tbl      (tbl_w)
    );

    lut5_read i_read (
        .tbl  (tbl_w),
        .sel  (sel),
        .out5 (out5),
        .out6 (out6)
    );

    assign tbl = tbl_w;
endmodule

// File: rtl/lut5_load_ctrl.sv
module lut5_load_ctrl #(
    parameter int unsigned TOTAL    = 64,
    parameter bit          CLK_FALL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic load_start,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = (TOTAL > 1) ? $clog2(TOTAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
    } lc_state_t;

    lc_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (load_start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end else if (s_q.busy && shift_en) begin
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    generate
        if (CLK_FALL) begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= s_d;
            end
        end else begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= s_d;
            end
        end
    endgenerate

    assign busy = s_q.busy;
    assign done = s_q.done;
endmodule

// File: rtl/lut5_shift_chain.sv
module lut5_shift_chain
    import lut5_pkg::*;
#(
    parameter int unsigned                     N_CELLS   = 2,
    parameter logic [N_CELLS*TBL_BITS-1:0]     CELL_INIT = '0,
    parameter bit                              CLK_FALL  = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_en,
    input  logic                          ser_in,
    output logic                          ser_out,
    input  logic [N_CELLS*LUT_INPUTS-1:0] lut_in,
    output logic [N_CELLS-1:0]            out5,
    output logic [N_CELLS-1:0]            out6,
    input  logic                          load_start,
    output logic                          load_busy,
    output logic                          load_done
);
    localparam int unsigned CHAIN_BITS = N_CELLS * TBL_BITS;

    logic [N_CELLS:0]        casc;
    logic [CHAIN_BITS-1:0]   tbl_all;

    assign casc[0] = ser_in;

    generate
        for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
            tbl_t cell_tbl;
            lut5_cell #(
                .INIT     (CELL_INIT[k*TBL_BITS +: TBL_BITS]),
                .CLK_FALL (CLK_FALL)
            ) i_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .shift_en (shift_en),
                .casc_in  (casc[k]),
                .casc_out (casc[k+1]),
                .sel      (lut_in[k*LUT_INPUTS +: LUT_INPUTS]),
                .out5     (out5[k]),
                .out6     (out6[k]),
                .tbl      (cell_tbl)
            );
            assign tbl_all[k*TBL_BITS +: TBL_BITS] = cell_tbl;
        end
    endgenerate

    assign ser_out = casc[N_CELLS];

    lut5_load_ctrl #(.TOTAL(CHAIN_BITS), .CLK_FALL(CLK_FALL)) i_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .load_start (load_start),
        .busy       (load_busy),
        .done       (load_done)
    );
endmodule

// File: rtl/lut5_chain_chk.sv
module lut5_chain_chk
    import lut5_pkg::*;
#(
    parameter int unsigned N_CELLS  = 2,
    parameter bit          CLK_FALL = 1'b0
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          shift_en,
    input logic                          ser_in,
    input logic [N_CELLS*LUT_INPUTS-1:0] lut_in,
    input logic [N_CELLS-1:0]            out5,
    input logic [N_CELLS-1:0]            out6,
    input logic                          load_start,
    input logic                          load_busy,
    input logic                          load_done,
    input logic [N_CELLS*TBL_BITS-1:0]   tbl_all
);
    localparam int unsigned CB = N_CELLS * TBL_BITS;

    logic chk_clk;
    assign chk_clk = CLK_FALL ? ~clk : clk;

    p_hold_r5: assert property (@(posedge chk_clk) disable iff (!rst_n)
        !shift_en |=> $stable(tbl_all));

    p_entry_r4: assert property (@(posedge chk_clk) disable iff (!rst_n)
        shift_en |=> tbl_all[0] == $past(ser_in));

    p_cascade_r6: assert property (@(posedge chk_clk) disable iff (!rst_n)
        shift_en |=> tbl_all[CB-1:1] == $past(tbl_all[CB-2:0]));

    p_done_pulse_r7: assert property (@(posedge chk_clk) disable iff (!rst_n)
        load_done |=> !load_done);

    p_start_busy_r7: assert property (@(posedge chk_clk) disable iff (!rst_n)
        load_start |=> load_busy);

    p_done_after_busy_r8: assert property (@(posedge chk_clk) disable iff (!rst_n)
        load_done |-> $past(load_busy) && !load_busy);

    generate
        for (genvar k = 0; k < N_CELLS; k++) begin : g_cell_chk
            p_half_agree_r3: assert property (@(posedge chk_clk) disable iff (!rst_n)
                !lut_in[k*LUT_INPUTS + HALF_SEL] |-> out5[k] == out6[k]);
        end
    endgenerate
endmodule

bind lut5_shift_chain lut5_chain_chk #(.N_CELLS(N_CELLS), .CLK_FALL(CLK_FALL)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .ser_in     (ser_in),
    .lut_in     (lut_in),
    .out5       (out5),
    .out6       (out6),
    .load_start (load_start),
    .load_busy  (load_busy),
    .load_done  (load_done),
    .tbl_all    (tbl_all)
);

// File: tb/test_lut5_shift_chain.sv
module test_lut5_shift_chain;
    localparam int unsigned NC = 2;
    localparam logic [63:0] INIT_V = 64'hC3A5_0F1E_9B27_6D48;
    localparam int unsigned NV = 5;
    localparam logic [63:0] VEC [NV] = '{
        64'h0123_4567_89AB_CDEF,
        64'hFFFF_0000_A5A5_5A5A,
        64'h8000_0001_7FFF_FFFE,
        64'hDEAD_BEEF_1357_9BDF,
        64'h0000_0000_FFFF_FFFF
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shift_en = 1'b0;
    logic        ser_in = 1'b0;
    logic        ser_out;
    logic [9:0]  lut_in = '0;
    logic [1:0]  out5, out6;
    logic        load_start = 1'b0;
    logic        load_busy, load_done;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    lut5_shift_chain #(.N_CELLS(NC), .CELL_INIT(INIT_V)) i_lut5_shift_chain (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(ser_in),
        .ser_out(ser_out), .lut_in(lut_in), .out5(out5), .out6(out6),
        .load_start(load_start), .load_busy(load_busy), .load_done(load_done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R2, R3: sweep every code on both cells against the expected tables
    task automatic sweep(input string req, input logic [63:0] exp);
        for (int code = 0; code < 32; code++) begin
            lut_in = {code[4:0], code[4:0]};
            #1;
            for (int k = 0; k < 2; k++) begin
                chk({req, " R2 out6"}, out6[k], exp[k*32 + code]);
                chk({req, " R3 out5"}, out5[k], exp[k*32 + code[3:0]]);
            end
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [63:0] cur;
        // R1: during and after reset
        #1;
        chk("R1 busy in reset", load_busy, 0);
        chk("R1 done in reset", load_done, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", load_busy, 0);
        chk("R1 done", load_done, 0);
        chk("R1/R6 ser_out", ser_out, INIT_V[63]);
        sweep("R1", INIT_V);
        cur = INIT_V;

        // R7, R6: counted loads of each vector
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            load_start = 1'b1;
            @(negedge clk);
            load_start = 1'b0;
            chk("R7 busy after start", load_busy, 1);
            for (int i = 0; i < 64; i++) begin
                if (i != 0) @(negedge clk);
                if (i == 63) begin
                    chk("R7 busy before last", load_busy, 1);
                    chk("R7 done early", load_done, 0);
                end
                shift_en = 1'b1;
                ser_in   = VEC[v][63-i];
            end
            @(negedge clk);
            shift_en = 1'b0;
            chk("R7 done", load_done, 1);
            chk("R7 busy cleared", load_busy, 0);
            chk("R6 ser_out", ser_out, VEC[v][63]);
            @(negedge clk);
            chk("R7 done one cycle", load_done, 0);
            sweep("R6 load", VEC[v]);
            cur = VEC[v];
        end

        // R5: enable low, toggling serial input
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            ser_in = i[0];
        end
        @(negedge clk);
        sweep("R5 hold", cur);

        // R4, R6, R8: uncounted shifts of a known pattern
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            shift_en = 1'b1;
            ser_in   = (i != 1) && (i != 4);
            cur      = {cur[62:0], ser_in};
            if (i != 0) chk("R8 no done", load_done, 0);
        end
        @(negedge clk);
        shift_en = 1'b0;
        chk("R8 no done after shifts", load_done, 0);
        chk("R8 not busy", load_busy, 0);
        chk("R6 ser_out after shift", ser_out, cur[63]);
        sweep("R4 shift", cur);

        // R3: i4 high selects upper halves, i4 low mirrors out5
        lut_in = {5'b10000, 5'b00000};
        #1;
        chk("R3 upper cell0", out6[0], cur[0]);
        chk("R3 upper cell1", out6[1], cur[48]);

        // R1: reset again restores initial tables
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sweep("R1 re-reset", INIT_V);

        summary();
    end
endmodule